// File: doc/BRIEF.md
# RMII Receive Byte Assembler

This block sits directly behind a reduced media-independent PHY interface and runs on the 50 MHz reference clock. Every clock it may receive one 2-bit data pair, qualified by a data-valid and a data-error input. While no frame is in progress it watches for the Ethernet frame start pattern: a long run of alternating bits (0x55 bytes) closed by the 0xD5 delimiter. It locks byte alignment on the dibit that completes the delimiter, packs the following dibits into bytes, and hands each byte out as a 9-bit word.

The same reference clock carries both link rates. At 100 Mb/s a new dibit arrives every cycle. At 10 Mb/s every dibit is repeated for ten reference cycles. The block tells the two apart by the length of the preamble run that precedes the delimiter. It then samples dibits at the matching rate and holds a speed code, so that the transmit side can send at the rate the link is using.

Top module: `rmii_rx_assembler`

## Requirements
- R1: Dibits are packed least-significant pair first: the first dibit sampled after lock becomes bits 1:0 of the first byte, and the fourth becomes bits 7:6.
- R2: A run of at least FAST_RUN_MIN (default 16) and fewer than SLOW_RUN_MIN (default 100) consecutive valid cycles carrying dibit 01, followed directly by dibit 11, locks a frame at 100 Mb/s. speed_code becomes 1 and every following valid cycle supplies one dibit.
- R3: A run of at least SLOW_RUN_MIN such cycles before the dibit 11 locks a frame at 10 Mb/s. speed_code becomes 0, and one dibit is sampled every tenth valid cycle, counted from the lock cycle.
- R4: A dibit 11 that follows a run shorter than FAST_RUN_MIN does not start a frame: no words are output for the bytes that follow it.
- R5: Bit 8 of word_out is 1 on the first byte of a frame (the first destination address byte) and 0 on every later byte of that frame.
- R6: Deasserting rx_valid ends the frame. A partly assembled byte is dropped, and no words are output until a new preamble and delimiter arrive.
- R7: rx_err asserted during a frame aborts it. No further words of that frame are output, and the block returns to searching for a preamble.
- R8: speed_code changes only when a new frame locks, and it is held across idle periods and rejected starts.
- R9: After reset, word_valid is 0 and speed_code is 1.
- R10: word_valid is a single-cycle pulse. Consecutive words of one frame are exactly 4 cycles apart at 100 Mb/s and exactly 40 cycles apart at 10 Mb/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_dibit | input | 2 | Data pair from the PHY |
| rx_valid | input | 1 | Data pair is valid (carrier present) |
| rx_err | input | 1 | PHY reports a receive error |
| word_out | output | 9 | Frame byte in bits 7:0, start-of-frame flag in bit 8 |
| word_valid | output | 1 | word_out holds a new byte this cycle |
| speed_code | output | 2 | Detected rate: 1 = 100 Mb/s, 0 = 10 Mb/s |

## Verification
A faulty preamble counter shows up at the ports as a wrong speed_code, or as a missed or spurious frame start. This is visible in the cycle after the delimiter dibit, or about four cycles later as a missing first word. A wrong sample pacer or packing index gives corrupted bytes or wrong word spacing on the very first word of a frame, so every frame is compared byte by byte, flag by flag and cycle by cycle. Abort handling is exposed by checking that no word appears after a dropped carrier or an error, and that the partial byte does not leak out.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RECV = 1'b1
    } rx_state_e;

    localparam logic [1:0] DIBIT_PREAMBLE  = 2'b01;
    localparam logic [1:0] DIBIT_DELIMITER = 2'b11;

    localparam logic [1:0] SPEED_10M  = 2'd0;
    localparam logic [1:0] SPEED_100M = 2'd1;

endpackage

// File: rtl/rmii_sfd_hunter.sv
module rmii_sfd_hunter #(
    parameter int FAST_RUN_MIN = 16,
    parameter int SLOW_RUN_MIN = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hunting,
    input  logic       rx_valid,
    input  logic       rx_err,
    input  logic [1:0] rx_dibit,
    output logic       lock,
    output logic       lock_slow
);
    import rmii_rx_pkg::*;

    localparam int RUN_W = $clog2(SLOW_RUN_MIN + 1);
    localparam logic [RUN_W-1:0] FAST_L = RUN_W'(FAST_RUN_MIN);
    localparam logic [RUN_W-1:0] SLOW_L = RUN_W'(SLOW_RUN_MIN);

    typedef struct packed {
        logic [RUN_W-1:0] run;
    } hunt_t;

    hunt_t cur_q, nxt_d;
    logic  clean;

    always_comb begin
        nxt_d = cur_q;
        clean = hunting && rx_valid && !rx_err;
        if (clean && rx_dibit == DIBIT_PREAMBLE) begin
            if (cur_q.run != SLOW_L) begin
                nxt_d.run = cur_q.run + 1'b1;
            end
        end else begin
            nxt_d.run = '0;
        end
        lock      = clean && (rx_dibit == DIBIT_DELIMITER) && (cur_q.run >= FAST_L);
        lock_slow = (cur_q.run >= SLOW_L);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/rmii_sample_pacer.sv
module rmii_sample_pacer #(
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic restart_slow,
    input  logic step,
    output logic strobe
);
    localparam int TICK_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [TICK_W-1:0] LAST = TICK_W'(SLOW_DIV - 1);

    typedef struct packed {
        logic              slow;
        logic [TICK_W-1:0] tick;
    } pace_t;

    pace_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (restart) begin
            nxt_d.slow = restart_slow;
            nxt_d.tick = '0;
        end else if (step) begin
            nxt_d.tick = (cur_q.tick == LAST) ? '0 : cur_q.tick + 1'b1;
        end
        strobe = step && (!cur_q.slow || cur_q.tick == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/rmii_dibit_packer.sv
module rmii_dibit_packer #(
    parameter int BYTE_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            take,
    input  logic [1:0]      dibit,
    output logic [BYTE_W:0] word_out,
    output logic            word_valid
);
    localparam int PAIRS = BYTE_W / 2;
    localparam int IDX_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAIRS - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] shreg;
        logic [IDX_W-1:0]  idx;
        logic              first;
        logic [BYTE_W:0]   word;
        logic              valid;
    } pack_t;

    pack_t cur_q, nxt_d;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        shifted     = {dibit, cur_q.shreg[BYTE_W-1:2]};
        if (start) begin
            nxt_d.shreg = '0;
            nxt_d.idx   = '0;
            nxt_d.first = 1'b1;
        end else if (take) begin
            nxt_d.shreg = shifted;
            if (cur_q.idx == IDX_LAST) begin
                nxt_d.idx   = '0;
                nxt_d.word  = {cur_q.first, shifted};
                nxt_d.valid = 1'b1;
                nxt_d.first = 1'b0;
            end else begin
                nxt_d.idx = cur_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign word_out   = cur_q.word;
    assign word_valid = cur_q.valid;

endmodule

// File: rtl/rmii_rx_assembler.sv
module rmii_rx_assembler #(
    parameter int FAST_RUN_MIN = 16,
    parameter int SLOW_RUN_MIN = 100,
    parameter int SLOW_DIV     = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rx_dibit,
    input  logic       rx_valid,
    input  logic       rx_err,
    output logic [8:0] word_out,
    output logic       word_valid,
    output logic [1:0] speed_code
);
    import rmii_rx_pkg::*;

    typedef struct packed {
        rx_state_e  state;
        logic [1:0] speed;
    } top_t;

    top_t cur_q, nxt_d;
    logic lock_w;
    logic lock_slow_w;
    logic step_w;
    logic strobe_w;

    rmii_sfd_hunter #(
        .FAST_RUN_MIN(FAST_RUN_MIN),
        .SLOW_RUN_MIN(SLOW_RUN_MIN)
    ) i_hunter (
        .clk      (clk),
        .rst_n    (rst_n),
        .hunting  (cur_q.state == ST_HUNT),
        .rx_valid (rx_valid),
        .rx_err   (rx_err),
        .rx_dibit (rx_dibit),
        .lock     (lock_w),
        .lock_slow(lock_slow_w)
    );

    rmii_sample_pacer #(
        .SLOW_DIV(SLOW_DIV)
    ) i_pacer (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (lock_w),
        .restart_slow(lock_slow_w),
        .step        (step_w),
        .strobe      (strobe_w)
    );

    rmii_dibit_packer #(
        .BYTE_W(8)
    ) i_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (lock_w),
        .take      (strobe_w),
        .dibit     (rx_dibit),
        .word_out  (word_out),
        .word_valid(word_valid)
    );

    always_comb begin
        nxt_d  = cur_q;
        step_w = (cur_q.state == ST_RECV) && rx_valid && !rx_err;
        case (cur_q.state)
            ST_HUNT: begin
                if (lock_w) begin
                    nxt_d.state = ST_RECV;
                    nxt_d.speed = lock_slow_w ? SPEED_10M : SPEED_100M;
                end
            end
            default: begin
                if (!rx_valid || rx_err) begin
                    nxt_d.state = ST_HUNT;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_HUNT;
            cur_q.speed <= SPEED_100M;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign speed_code = cur_q.speed;

endmodule

// File: rtl/rmii_rx_assembler_checker.sv
module rmii_rx_assembler_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_err,
    input logic       word_valid,
    input logic [1:0] speed_code,
    input logic       lock
);

    // R10: a word is a single-cycle pulse
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R6: a word only follows a cycle with carrier present and no error
    p_word_needs_carrier_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(rx_valid && !rx_err));

    // R7: an error cycle never yields a word on the next cycle
    p_err_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> !word_valid);

    // R8: the speed code moves only after a frame lock
    p_speed_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> $stable(speed_code));

    // R3: only the two defined speed codes ever appear
    p_speed_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        speed_code inside {2'd0, 2'd1});

endmodule

bind rmii_rx_assembler rmii_rx_assembler_checker i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_err    (rx_err),
    .word_valid(word_valid),
    .speed_code(speed_code),
    .lock      (lock_w)
);

// File: tb/test_rmii_rx_assembler.sv
module test_rmii_rx_assembler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rx_dibit = 2'b00;
    logic       rx_valid = 1'b0;
    logic       rx_err = 1'b0;
    logic [8:0] word_out;
    logic       word_valid;
    logic [1:0] speed_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [7:0] tx_b [0:63];
    logic [7:0] got_b [0:255];
    logic       got_f [0:255];
    int         got_t [0:255];
    int         gotn = 0;

    always #2 clk = ~clk;

    rmii_rx_assembler i_rmii_rx_assembler (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_dibit  (rx_dibit),
        .rx_valid  (rx_valid),
        .rx_err    (rx_err),
        .word_out  (word_out),
        .word_valid(word_valid),
        .speed_code(speed_code)
    );

    always @(posedge clk) begin
        cyc = cyc + 1;
        #1;
        if (word_valid && gotn < 256) begin
            got_b[gotn] = word_out[7:0];
            got_f[gotn] = word_out[8];
            got_t[gotn] = cyc;
            gotn = gotn + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] d, input logic v, input logic e, input int reps);
        repeat (reps) begin
            @(negedge clk);
            rx_dibit = d;
            rx_valid = v;
            rx_err   = e;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int reps);
        for (int k = 0; k < 4; k++) drive(b[2*k +: 2], 1'b1, 1'b0, reps);
    endtask

    task automatic send_start(input int run, input int reps);
        drive(2'b01, 1'b1, 1'b0, run * reps);
        drive(2'b11, 1'b1, 1'b0, reps);
    endtask

    task automatic idle(input int n);
        drive(2'b00, 1'b0, 1'b0, n);
    endtask

    // Full frame from tx_b[0..n-1], then compare stream, flags and spacing.
    task automatic frame_and_check(input bit slow, input int n, input string tag);
        int reps;
        reps = slow ? 10 : 1;
        gotn = 0;
        send_start(slow ? 31 : 31, reps);
        for (int i = 0; i < n; i++) send_byte(tx_b[i], reps);
        idle(6);
        check(gotn == n, {tag, " word count"}, gotn, n);
        for (int i = 0; i < n && i < gotn; i++) begin
            check(got_b[i] == tx_b[i], {tag, " R1 byte"}, got_b[i], tx_b[i]);
            check(got_f[i] == (i == 0), "R5 start flag", got_f[i], (i == 0));
            if (i > 0)
                check(got_t[i] - got_t[i-1] == 4 * reps, "R10 word spacing",
                      got_t[i] - got_t[i-1], 4 * reps);
        end
        check(speed_code == (slow ? 2'd0 : 2'd1), slow ? "R3 speed" : "R2 speed",
              speed_code, slow ? 0 : 1);
    endtask

    initial begin
        #600000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(word_valid == 1'b0, "R9 reset valid", word_valid, 0);
        check(speed_code == 2'd1, "R9 reset speed", speed_code, 1);

        // Directed: dibit order, 100 Mb/s
        tx_b[0] = 8'h1B; tx_b[1] = 8'hE4; tx_b[2] = 8'hD5; tx_b[3] = 8'h55;
        frame_and_check(1'b0, 4, "R2 fast directed");

        // Directed: 10 Mb/s
        tx_b[0] = 8'hA5; tx_b[1] = 8'h3C; tx_b[2] = 8'h00;
        frame_and_check(1'b1, 3, "R3 slow directed");

        // R4: too short a run; R8: speed unchanged (still 0)
        gotn = 0;
        send_start(10, 1);
        for (int i = 0; i < 3; i++) send_byte(8'h00, 1);
        idle(6);
        check(gotn == 0, "R4 short run rejected", gotn, 0);
        check(speed_code == 2'd0, "R8 speed held", speed_code, 0);

        // R6: carrier drops mid byte; then data without preamble
        gotn = 0;
        send_start(31, 1);
        send_byte(8'h12, 1);
        send_byte(8'h34, 1);
        drive(2'b10, 1'b1, 1'b0, 2);
        idle(3);
        for (int i = 0; i < 4; i++) send_byte(8'h00, 1);
        idle(6);
        check(gotn == 2, "R6 truncated frame count", gotn, 2);
        check(gotn >= 2 && got_b[1] == 8'h34, "R6 last whole byte", got_b[1], 8'h34);

        // R7: error mid frame with carrier held
        gotn = 0;
        send_start(31, 1);
        send_byte(8'hAA, 1);
        send_byte(8'h3C, 1);
        drive(2'b00, 1'b1, 1'b1, 1);
        drive(2'b00, 1'b1, 1'b0, 3);
        for (int i = 0; i < 3; i++) send_byte(8'h00, 1);
        idle(6);
        check(gotn == 2, "R7 abort on error", gotn, 2);

        // Random frames of both speeds
        for (int f = 0; f < 8; f++) begin
            int n;
            bit slow;
            n = 1 + int'($urandom % 10);
            slow = ($urandom % 3) == 0;
            for (int i = 0; i < n; i++) tx_b[i] = 8'($urandom);
            frame_and_check(slow, n, "R1 random");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule